// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns 16-bit virtual addresses into 15-bit physical addresses for a 32 KB memory split into 1 KB pages. The lower ten bits of an address are the byte offset and pass through unchanged. The upper six bits are a page number that is mapped to a five-bit frame number. A four-entry, fully associative translation cache is searched first. On a miss, the block reads one page-table word from memory at the base address plus the page number. A resident entry is installed into the cache over a round-robin victim, and the request then completes. A non-resident entry produces a fault response and leaves the cache untouched.

The block also keeps the usage flags in the page table up to date. Every successful translation sets the reference flag, and a write access sets the dirty flag. Whenever an update changes the stored word, the block writes it back through the same memory port. The flush pin empties the cache in one cycle. It is meant for the moment the base register is changed on a context switch. Software keeps `pt_base` stable while a request is in flight.

Requests and responses use valid/ready handshakes, with one request outstanding at a time. `req_ready` is high only while the block is idle, so a requester stalls by holding `req_valid`. A response stays presented, with its address and fault flag frozen, for as long as the consumer holds `rsp_ready` low. The memory port uses a request/grant pair and may stall for any number of cycles.

Top module: `tlb_xlate`

## Requirements
- R1: The physical address is {frame, vaddr[9:0]}. The page number is vaddr[15:10], the frame occupies paddr[14:10], and the offset is copied without change.
- R2: On a cache miss, the block issues exactly one memory read, at address `pt_base` + page number (zero-extended).
- R3: A page-table word holds the frame in bits 4:0, the resident flag in bit 5, the reference flag in bit 6 and the dirty flag in bit 7. Write-backs keep this layout.
- R4: A read hit, or a write hit on an entry already marked dirty, makes no memory access. In this case `rsp_valid` rises two cycles after the request handshake cycle.
- R5: On a miss to a resident page, the block installs the translation and responds with the fetched frame. A later access to the same page then hits.
- R6: On a miss to a non-resident page, the block responds with `rsp_fault`=1 and `rsp_paddr`=0. It makes no write and installs nothing, so the next access to that page reads memory again.
- R7: On a miss, the written-back word is the fetched word with the reference flag set, and with the dirty flag also set for a write access. The write happens only if this word differs from the fetched one.
- R8: A write hit on a clean cache entry writes back {dirty=1, reference=1, resident=1, frame}, with all other bits zero. It marks the cache entry dirty, so the next write hit to that page makes no access.
- R9: Fills replace entries in round-robin order. The order starts at entry 0 after reset or a flush, so the fifth distinct page evicts the first.
- R10: A one-cycle `flush` pulse invalidates every cache entry, so the next access to any page misses.
- R11: `req_ready` is high only when no request is in progress. It is low during the cycle after a request is accepted.
- R12: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold their values.
- R13: While `mem_req` is high without `mem_gnt`, the values of `mem_addr`, `mem_we` and `mem_wdata` hold. Read data is taken in any later cycle in which `mem_rvalid` is high.
- R14: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_req`=0, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cache entries |
| pt_base | input | 16 | Page-table base address |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 16 | Virtual address |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_paddr | output | 15 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Page not resident |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_gnt | input | 1 | Memory accepts the access |
| mem_addr | output | 16 | Page-table word address |
| mem_wdata | output | 16 | Page-table word to write |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |

## Verification
A corrupted valid bit or page tag in the cache shows up on the very next request to the affected page. That request either makes an unexpected memory read, or it skips the read and returns a wrong frame. A lost dirty flag shows one write later, as an extra or a missing write-back. A wrong round-robin pointer shows only once a fifth distinct page forces an eviction, as a hit or a miss on the wrong page. A fault that wrongly fills the cache shows as a missing read when the same page is requested again. The bench predicts hits, misses, frames and page-table contents with its own model, and compares every response and memory access against it.

// File: rtl/tlb_xlate_pkg.sv
`timescale 1ns/1ps
package tlb_xlate_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_RD,
    ST_RDW,
    ST_WB,
    ST_RESP
  } xl_state_e;
endpackage

// File: rtl/tlb_rr_victim.sv
`timescale 1ns/1ps
module tlb_rr_victim #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             advance,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      ptr_q <= '0;
    end else if (advance) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_q <= '0;
      else                              ptr_q <= ptr_q + 1'b1;
    end
  end

  assign victim = ptr_q;
endmodule

// File: rtl/tlb_store.sv
`timescale 1ns/1ps
module tlb_store #(
  parameter int ENTRIES = 4,
  parameter int PAGE_W  = 6,
  parameter int FRAME_W = 5,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               lk_dirty,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_dirty,
  input  logic               mark_en,
  input  logic [IDX_W-1:0]   mark_idx
);
  logic [ENTRIES-1:0]         match;
  logic [ENTRIES-1:0]         dirty_vec;
  logic [ENTRIES*FRAME_W-1:0] frame_flat;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic               v_q;
    logic               d_q;
    logic [PAGE_W-1:0]  pg_q;
    logic [FRAME_W-1:0] fr_q;

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        v_q  <= 1'b0;
        d_q  <= 1'b0;
        pg_q <= '0;
        fr_q <= '0;
      end else if (fill_en && fill_idx == IDX_W'(g)) begin
        v_q  <= 1'b1;
        d_q  <= fill_dirty;
        pg_q <= fill_page;
        fr_q <= fill_frame;
      end else if (mark_en && mark_idx == IDX_W'(g)) begin
        d_q  <= 1'b1;
      end
    end

    assign match[g] = v_q && (pg_q == lk_page);
    assign dirty_vec[g] = d_q;
    assign frame_flat[g*FRAME_W +: FRAME_W] = fr_q;
  end

  always_comb begin
    lk_idx   = '0;
    lk_frame = '0;
    lk_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_idx   = IDX_W'(i);
        lk_frame = frame_flat[i*FRAME_W +: FRAME_W];
        lk_dirty = dirty_vec[i];
      end
    end
  end

  assign lk_hit = |match;
endmodule

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
module tlb_xlate
  import tlb_xlate_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int PA_W    = 15,
  parameter int OFF_W   = 10,
  parameter int ENTRIES = 4,
  parameter int MEM_AW  = 16,
  parameter int MEM_DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [MEM_AW-1:0] pt_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_req,
  output logic              mem_we,
  input  logic              mem_gnt,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [MEM_DW-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [MEM_DW-1:0] mem_rdata
);
  localparam int PAGE_W  = VA_W - OFF_W;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int RES_B   = FRAME_W;
  localparam int REF_B   = FRAME_W + 1;
  localparam int DRT_B   = FRAME_W + 2;

  xl_state_e          state_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [MEM_AW-1:0]  pte_addr_q;
  logic [PA_W-1:0]    paddr_q;
  logic               fault_q;
  logic [MEM_DW-1:0]  wdata_q;

  logic [PAGE_W-1:0]  cur_page;
  logic [OFF_W-1:0]   cur_off;
  logic               lk_hit, lk_dirty;
  logic [IDX_W-1:0]   lk_idx, victim;
  logic [FRAME_W-1:0] lk_frame;
  logic               fill_en, mark_en;
  logic [MEM_DW-1:0]  hit_word, upd_word;

  assign cur_page = va_q[VA_W-1:OFF_W];
  assign cur_off  = va_q[OFF_W-1:0];

  tlb_store #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) i_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_page(cur_page), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_frame(lk_frame), .lk_dirty(lk_dirty),
    .fill_en(fill_en), .fill_idx(victim), .fill_page(cur_page),
    .fill_frame(mem_rdata[FRAME_W-1:0]), .fill_dirty(upd_word[DRT_B]),
    .mark_en(mark_en), .mark_idx(lk_idx)
  );

  tlb_rr_victim #(.ENTRIES(ENTRIES)) i_victim (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .advance(fill_en), .victim(victim)
  );

  always_comb begin
    hit_word = '0;
    hit_word[FRAME_W-1:0] = lk_frame;
    hit_word[RES_B] = 1'b1;
    hit_word[REF_B] = 1'b1;
    hit_word[DRT_B] = 1'b1;
    upd_word = mem_rdata;
    upd_word[REF_B] = 1'b1;
    if (wr_q) upd_word[DRT_B] = 1'b1;
  end

  assign mark_en = (state_q == ST_LOOKUP) && lk_hit && wr_q && !lk_dirty;
  assign fill_en = (state_q == ST_RDW) && mem_rvalid && mem_rdata[RES_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      pte_addr_q <= '0;
      paddr_q    <= '0;
      fault_q    <= 1'b0;
      wdata_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q       <= req_vaddr;
          wr_q       <= req_write;
          pte_addr_q <= pt_base + MEM_AW'(req_vaddr[VA_W-1:OFF_W]);
          state_q    <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (lk_hit) begin
            paddr_q <= {lk_frame, cur_off};
            fault_q <= 1'b0;
            if (mark_en) begin
              wdata_q <= hit_word;
              state_q <= ST_WB;
            end else begin
              state_q <= ST_RESP;
            end
          end else begin
            state_q <= ST_RD;
          end
        end
        ST_RD: if (mem_gnt) state_q <= ST_RDW;
        ST_RDW: if (mem_rvalid) begin
          if (!mem_rdata[RES_B]) begin
            fault_q <= 1'b1;
            paddr_q <= '0;
            state_q <= ST_RESP;
          end else begin
            fault_q <= 1'b0;
            paddr_q <= {mem_rdata[FRAME_W-1:0], cur_off};
            wdata_q <= upd_word;
            state_q <= (upd_word != mem_rdata) ? ST_WB : ST_RESP;
          end
        end
        ST_WB: if (mem_gnt) state_q <= ST_RESP;
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;
  assign mem_req   = (state_q == ST_RD) || (state_q == ST_WB);
  assign mem_we    = (state_q == ST_WB);
  assign mem_addr  = pte_addr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/tlb_xlate_chk.sv
`timescale 1ns/1ps
module tlb_xlate_chk #(
  parameter int VA_W   = 16,
  parameter int PA_W   = 15,
  parameter int OFF_W  = 10,
  parameter int MEM_AW = 16,
  parameter int MEM_DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MEM_AW-1:0] pt_base,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              rsp_fault,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [MEM_DW-1:0] mem_wdata
);
  localparam int PAGE_W  = VA_W - OFF_W;
  localparam int FRAME_W = PA_W - OFF_W;

  logic [OFF_W-1:0]  off_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      page_q <= '0;
    end else if (req_valid && req_ready) begin
      off_q  <= req_vaddr[OFF_W-1:0];
      page_q <= req_vaddr[VA_W-1:OFF_W];
    end
  end

  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == off_q);

  assert_pte_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr == pt_base + MEM_AW'(page_q));

  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  assert_wb_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[FRAME_W] && mem_wdata[FRAME_W+1]);

  assert_single_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .MEM_AW(MEM_AW), .MEM_DW(MEM_DW)
) i_tlb_xlate_chk (
  .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
  .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
  logic        clk, rst_n, flush;
  logic [15:0] pt_base;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_vaddr;
  logic        rsp_valid, rsp_ready, rsp_fault;
  logic [14:0] rsp_paddr;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  tlb_xlate i_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;
  logic [15:0] mem    [0:1023];
  logic [15:0] pt_exp [0:1023];
  logic [15:0] last_rd_a;
  bit          m_v  [4];
  bit          m_d  [4];
  logic [5:0]  m_pg [4];
  int          m_ptr;

  task automatic check_val(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory responder: grant at random, read data one cycle after grant
  initial begin
    bit pend, pend_we;
    logic [15:0] pend_a, pend_d;
    pend = 0; pend_we = 0; pend_a = 0; pend_d = 0;
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = 0; last_rd_a = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (pend) begin
        if (pend_we) begin
          mem[pend_a[9:0]] = pend_d;
          n_wr++;
        end else begin
          mem_rvalid = 1;
          mem_rdata  = mem[pend_a[9:0]];
          last_rd_a  = pend_a;
          n_rd++;
        end
      end
      mem_gnt = rst_n && (($urandom % 4) != 0);
      pend    = mem_gnt && mem_req;
      pend_we = mem_we;
      pend_a  = mem_addr;
      pend_d  = mem_wdata;
    end
  end

  task automatic set_pte(logic [15:0] a, logic [4:0] fr, bit res, bit rf, bit dt);
    mem[a[9:0]]    = {8'h00, dt, rf, res, fr};
    pt_exp[a[9:0]] = {8'h00, dt, rf, res, fr};
  endtask

  task automatic do_flush(logic [15:0] new_base);
    @(negedge clk);
    flush = 1; pt_base = new_base;
    @(negedge clk);
    flush = 0;
    for (int i = 0; i < 4; i++) m_v[i] = 0;
    m_ptr = 0;
  endtask

  task automatic do_req(logic [15:0] va, bit w, string rd_tag);
    logic [5:0]  page;
    logic [15:0] a, pte, nw;
    int hit_i, e_rd, e_wr, rd0, wr0, cyc, first_cyc;
    bit e_fault, fast, seen;
    logic [14:0] e_pa, first_pa, fin_pa;
    bit first_f, fin_f;
    page = va[15:10];
    a = pt_base + {10'd0, page};
    hit_i = -1;
    for (int i = 0; i < 4; i++) if (m_v[i] && m_pg[i] == page) hit_i = i;
    pte = pt_exp[a[9:0]];
    e_fault = 0; e_wr = 0; fast = 0;
    if (hit_i >= 0) begin
      e_rd = 0;
      e_pa = {pte[4:0], va[9:0]};
      if (w && !m_d[hit_i]) begin
        e_wr = 1;
        pt_exp[a[9:0]] = {8'h00, 3'b111, pte[4:0]};
        m_d[hit_i] = 1;
      end else fast = 1;
    end else begin
      e_rd = 1;
      if (!pte[5]) begin
        e_fault = 1; e_pa = 0;
      end else begin
        nw = pte | 16'h0040 | (w ? 16'h0080 : 16'h0000);
        e_wr = (nw != pte) ? 1 : 0;
        pt_exp[a[9:0]] = nw;
        m_pg[m_ptr] = page; m_v[m_ptr] = 1; m_d[m_ptr] = nw[7];
        m_ptr = (m_ptr + 1) % 4;
        e_pa = {pte[4:0], va[9:0]};
      end
    end
    if (rd_tag == "") rd_tag = (hit_i >= 0) ? "R4" : "R5";

    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk);
    req_vaddr = va; req_write = w; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check_val("R11", "req_ready after accept", int'(req_ready), 0);
    cyc = 1; seen = 0; first_cyc = 0; first_pa = 0; first_f = 0; fin_pa = 0; fin_f = 0;
    forever begin
      if (rsp_valid) begin
        if (!seen) begin
          seen = 1; first_cyc = cyc; first_pa = rsp_paddr; first_f = rsp_fault;
        end
        rsp_ready = (($urandom % 3) != 0);
        if (rsp_ready) begin
          fin_pa = rsp_paddr; fin_f = rsp_fault;
          break;
        end
      end
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    rsp_ready = 0;

    check_val("R6", "fault flag", int'(fin_f), int'(e_fault));
    check_val(e_fault ? "R6" : rd_tag, "physical address", int'(fin_pa), int'(e_pa));
    if (!e_fault) check_val("R1", "offset bits", int'(fin_pa[9:0]), int'(va[9:0]));
    check_val("R12", "held address", int'(first_pa), int'(fin_pa));
    check_val("R12", "held fault", int'(first_f), int'(fin_f));
    check_val(rd_tag, "memory reads", n_rd - rd0, e_rd);
    if (e_rd == 1) check_val("R2", "entry read address", int'(last_rd_a), int'(a));
    check_val((hit_i >= 0) ? "R8" : "R7", "memory writes", n_wr - wr0, e_wr);
    check_val("R13", "memory accesses", (n_rd - rd0) + (n_wr - wr0), e_rd + e_wr);
    check_val("R3", "page-table word", int'(mem[a[9:0]]), int'(pt_exp[a[9:0]]));
    if (fast) check_val("R4", "hit latency", first_cyc, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; flush = 0; pt_base = 16'h0100;
    req_valid = 0; req_vaddr = 0; req_write = 0; rsp_ready = 0;
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] v;
      v = {8'h00, 3'($urandom), 5'($urandom)};
      if (($urandom % 6) != 0) v[5] = 1'b1;
      mem[i] = v; pt_exp[i] = v;
    end
    for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_d[i] = 0; m_pg[i] = 0; end
    m_ptr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_val("R14", "req_ready", int'(req_ready), 1);
    check_val("R14", "rsp_valid", int'(rsp_valid), 0);
    check_val("R14", "mem_req", int'(mem_req), 0);

    // R14/R5/R7: empty cache, clean unreferenced entry fetched and marked
    set_pte(16'h0103, 5'd17, 1, 0, 0);
    do_req({6'd3, 10'h155}, 0, "R14");
    do_req({6'd3, 10'h3FF}, 0, "");          // R4 read hit
    do_req({6'd3, 10'h000}, 1, "");          // R8 write hit on clean entry
    do_req({6'd3, 10'h201}, 1, "");          // R8 dirty hit: no write
    // R7: already referenced and dirty: no write-back on miss
    set_pte(16'h0104, 5'd2, 1, 1, 1);
    do_req({6'd4, 10'h0AA}, 1, "");
    // R6: non-resident page faults and is not installed
    set_pte(16'h0109, 5'd9, 0, 0, 0);
    do_req({6'd9, 10'h123}, 0, "R6");
    do_req({6'd9, 10'h321}, 1, "R6");

    // R9: round-robin replacement from slot 0 after flush
    do_flush(16'h0100);
    for (int p = 10; p < 15; p++) set_pte(16'h0100 + 16'(p), 5'(p + 3), 1, 1, 0);
    for (int p = 10; p < 14; p++) do_req({6'(p), 10'h010}, 0, "R9");
    do_req({6'd14, 10'h011}, 0, "R9");       // evicts page 10
    do_req({6'd11, 10'h012}, 0, "R9");       // still present
    do_req({6'd10, 10'h013}, 0, "R9");       // miss, evicts page 11
    do_req({6'd11, 10'h014}, 0, "R9");       // miss again

    // R10: flush empties the cache; new base region
    do_flush(16'h0280);
    do_req({6'd12, 10'h2A2}, 0, "R10");
    do_req({6'd12, 10'h2A3}, 0, "");

    // random mix
    for (int n = 0; n < 250; n++) begin
      logic [15:0] va;
      if (($urandom % 25) == 0) do_flush((($urandom % 2) == 0) ? 16'h0100 : 16'h0280);
      va = {6'($urandom % 12), 10'($urandom)};
      do_req(va, (($urandom % 3) == 0), "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule